// File: doc/BRIEF.md
# Interconnect Port Snoop Enable Controller

This block holds the snoop-request and DVM-request enables for the slave ports of a coherent interconnect, five ports by default. Software writes a two-bit enable value into a port's control register. If the value differs from the one in force, the port starts a transition. A change that withdraws an enable first waits for the port's outstanding traffic to drain. Every change then waits a fixed settle time before the new value reaches the port's enable outputs.

A shared status register reports, in bit 0, whether any port still has a change in flight. Software polls it after each control write and continues once it reads zero. The register bus never stalls. A write that arrives while its port is still busy is parked in a one-entry slot for that port, and the port takes it up once the current change has finished.

Top module: `snoop_port_ctl`

## Requirements
- R1: After a clock edge with `rst_n` low, every port's snoop and DVM enables are 0 and status bit 0 reads 0.
- R2: Port p (0-based) has its control register at address `(p+1) << 12`. Bit 0 is the snoop enable and bit 1 is the DVM enable. Reading that address returns the value currently in force, which is the same value shown on `snoop_en[p]` and `dvm_en[p]`.
- R3: Address 0x00C is the status register. Its bit 0 reads 1 while any port has a change in progress or a parked write, and 0 otherwise. All other bits read 0.
- R4: A write that only adds enable bits takes effect SETTLE_CYC clock edges after the edge that captured it. Status bit 0 falls on that same edge.
- R5: A write that removes any enable bit keeps the old value while `txn_busy[p]` is high. The new value takes effect SETTLE_CYC edges after the first edge, later than the write edge, at which `txn_busy[p]` is sampled low.
- R6: A write of the value already in force, to an idle port with nothing parked, changes nothing and leaves status bit 0 at 0.
- R7: Writes to a port with a change in progress are parked one deep, and the latest one wins. The parked value is taken up on the edge after the current change completes. It then follows R4, R5 or R6 against the newly applied value.
- R8: Address 0xFE8 reads the REV parameter in bits 7:4, with all other bits 0.
- R9: Writes to any address other than a port control register have no effect on any port or on the status.
- R10: A transition on one port leaves the enables of every other port unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register byte address for reads and writes |
| reg_wdata | input | 2 | Write data: bit 0 is the snoop enable, bit 1 the DVM enable |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| txn_busy | input | NPORT | High while the port still has outstanding transactions |
| snoop_en | output | NPORT | Snoop request enable in force, per port |
| dvm_en | output | NPORT | DVM request enable in force, per port |

## Verification
Read data follows `reg_addr` within the same cycle. An enable-only change lands SETTLE_CYC edges after the write edge. A disabling change lands SETTLE_CYC edges after the first edge that sees `txn_busy` low, and a parked write starts one edge after the preceding change lands. The bench drives inputs and samples outputs at falling edges. It counts edges from the write, checks that the old value and a busy status hold one edge before the due edge, and checks the new value and a clear status one edge after it. Directed cases cover parking, last-wins replacement, ignored addresses and same-value writes. Seeded random writes with random drain lengths are scored against the same timing rules.

// File: rtl/snp_pkg.sv
// Package: shared types and register offsets for the port snoop enable controller.
// Assumes 4 KiB register windows: window 0 is global, window p+1 is port p.
package snp_pkg;

    // Width of the per-port enable field: bit 0 snoop, bit 1 DVM.
    localparam int EN_W = 2;

    // Offsets within a 4 KiB window.
    localparam logic [11:0] OFF_CTRL   = 12'h000;
    localparam logic [11:0] OFF_STATUS = 12'h00C;
    localparam logic [11:0] OFF_ID     = 12'hFE8;

    // Per-port transition state.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_SETTLE = 2'd2
    } port_state_t;

endpackage

// File: rtl/snp_reg_decode.sv
// Module: address decode and read mux for the controller's register space.
// Produces one write strobe per port control register and the combinational
// read data. Assumes ADDR_W > 12; bits above 11 select the window.
module snp_reg_decode
    import snp_pkg::*;
#(
    parameter int          NPORT  = 5,
    parameter int          ADDR_W = 16,
    parameter int          DATA_W = 32,
    parameter logic [3:0]  REV    = 4'h1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [NPORT-1:0][EN_W-1:0] port_en,
    input  logic                       busy_any,
    output logic [NPORT-1:0]           wr_hit,
    output logic [DATA_W-1:0]          rdata
);

    localparam int WIN_W = ADDR_W - 12;

    logic [WIN_W-1:0] win;
    logic [11:0]      off;

    assign win = reg_addr[ADDR_W-1:12];
    assign off = reg_addr[11:0];

    // One write strobe per port control register.
    for (genvar p = 0; p < NPORT; p++) begin : g_hit
        assign wr_hit[p] = reg_wr && (off == OFF_CTRL) && (win == WIN_W'(p + 1));
    end

    // Read mux: global status and ID in window 0, port control values elsewhere.
    always_comb begin
        rdata = '0;
        if (win == '0) begin
            if (off == OFF_STATUS)  rdata[0]   = busy_any;
            else if (off == OFF_ID) rdata[7:4] = REV;
        end
        for (int p = 0; p < NPORT; p++) begin
            if (win == WIN_W'(p + 1) && off == OFF_CTRL) rdata[EN_W-1:0] = port_en[p];
        end
    end

    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $onehot0(wr_hit)); // R2
    AST_NO_WR_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |-> (wr_hit == '0)); // R9

endmodule

// File: rtl/snp_port_fsm.sv
// Module: one port's enable transition engine.
// A write that differs from the value in force starts a transition. One that
// clears any bit drains first (waits for txn_busy low), then every transition
// settles for SETTLE_CYC cycles before the target is applied. Writes made while
// busy are parked one deep, last wins, and are taken up one edge after apply.
// Assumes SETTLE_CYC >= 1.
module snp_port_fsm
    import snp_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic [EN_W-1:0] wr_val,
    input  logic            txn_busy,
    output logic [EN_W-1:0] en,
    output logic            busy
);

    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC - 1);

    port_state_t     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [EN_W-1:0] en_q, tgt_q, q_data;
    logic            q_val;

    logic            idle, take_q, start_req, start_change, clears, settle_done;
    logic [EN_W-1:0] start_val;

    // Decide whether a transition starts this cycle and from which source.
    always_comb begin
        idle         = (state_q == ST_IDLE);
        take_q       = idle && q_val;
        start_req    = take_q || (idle && !q_val && wr_req);
        start_val    = take_q ? q_data : wr_val;
        start_change = start_req && (start_val != en_q);
        clears       = |(en_q & ~start_val);
        settle_done  = (state_q == ST_SETTLE) && (cnt_q == '0);
    end

    // One-deep parking slot for writes that arrive while the port is busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_val  <= 1'b0;
            q_data <= '0;
        end else if (wr_req && (!idle || q_val)) begin
            q_val  <= 1'b1;
            q_data <= wr_val;
        end else if (take_q) begin
            q_val  <= 1'b0;
        end
    end

    // Transition sequencer: drain, settle count, apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            en_q    <= '0;
            tgt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_change) begin
                        tgt_q   <= start_val;
                        cnt_q   <= CNT_LOAD;
                        state_q <= clears ? ST_DRAIN : ST_SETTLE;
                    end
                end
                ST_DRAIN: begin
                    if (!txn_busy) begin
                        cnt_q   <= CNT_LOAD;
                        state_q <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (cnt_q == '0) begin
                        en_q    <= tgt_q;
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q   <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign en   = en_q;
    assign busy = !idle || q_val;

    AST_EN_ONLY_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !settle_done |=> $stable(en_q)); // R4
    AST_SETTLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> (cnt_q < CNT_W'(SETTLE_CYC))); // R4
    AST_DRAIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && txn_busy) |=> (state_q == ST_DRAIN)); // R5
    AST_SAME_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !q_val && wr_req && wr_val == en_q) |=>
        (state_q == ST_IDLE && !q_val && $stable(en_q))); // R6
    AST_BUSY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_val != en_q) |=> busy); // R3
    AST_PARK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && wr_req) |=> (q_val && q_data == $past(wr_val))); // R7

endmodule

// File: rtl/snoop_port_ctl.sv
// Module: top of the port snoop enable controller.
// Decodes the register bus, runs one transition engine per port and folds
// their busy flags into the global status bit. Register bus writes complete
// in one cycle, reads are combinational.
module snoop_port_ctl
    import snp_pkg::*;
#(
    parameter int         NPORT      = 5,
    parameter int         ADDR_W     = 16,
    parameter int         DATA_W     = 32,
    parameter int         SETTLE_CYC = 4,
    parameter logic [3:0] REV        = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [EN_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NPORT-1:0]  txn_busy,
    output logic [NPORT-1:0]  snoop_en,
    output logic [NPORT-1:0]  dvm_en
);

    logic [NPORT-1:0]           wr_hit;
    logic [NPORT-1:0]           port_busy;
    logic [NPORT-1:0][EN_W-1:0] port_en;
    logic                       busy_any;

    // Global busy: any port mid-change or holding a parked write.
    assign busy_any = |port_busy;

    snp_reg_decode #(
        .NPORT  (NPORT),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .REV    (REV)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .port_en  (port_en),
        .busy_any (busy_any),
        .wr_hit   (wr_hit),
        .rdata    (reg_rdata)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        snp_port_fsm #(
            .SETTLE_CYC (SETTLE_CYC)
        ) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_req   (wr_hit[p]),
            .wr_val   (reg_wdata),
            .txn_busy (txn_busy[p]),
            .en       (port_en[p]),
            .busy     (port_busy[p])
        );
        assign snoop_en[p] = port_en[p][0];
        assign dvm_en[p]   = port_en[p][1];
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (snoop_en == '0 && dvm_en == '0 && !busy_any)); // R1
    AST_OTHERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_any && !reg_wr) |=> ($stable(snoop_en) && $stable(dvm_en))); // R10

endmodule

// File: tb/snoop_port_ctl_tb.sv
// Bench: directed corner cases plus seeded random enable changes, timed from
// the requirements and sampled at falling edges.
module snoop_port_ctl_tb;

    localparam int         NP   = 5;
    localparam int         N    = 4;
    localparam int         AW   = 16;
    localparam int         DW   = 32;
    localparam logic [3:0] REVV = 4'h5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [1:0]    reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [NP-1:0] txn_busy = '0;
    logic [NP-1:0] snoop_en, dvm_en;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] exp_en [NP];

    always #4 clk = ~clk;

    snoop_port_ctl #(
        .NPORT(NP), .ADDR_W(AW), .DATA_W(DW), .SETTLE_CYC(N), .REV(REVV)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txn_busy(txn_busy),
        .snoop_en(snoop_en), .dvm_en(dvm_en)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ctl_addr(int p);
        return AW'((p + 1) << 12);
    endfunction

    task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk_port(string req, int p, logic [1:0] e);
        logic [DW-1:0] d;
        rd(ctl_addr(p), d);
        chk(req, $sformatf("port%0d readback", p), d, {30'b0, e});
        chk(req, $sformatf("port%0d pins", p), {30'b0, dvm_en[p], snoop_en[p]}, {30'b0, e});
    endtask

    task automatic chk_status(string req, logic e);
        logic [DW-1:0] d;
        rd(AW'(12'h00C), d);
        chk(req, "status", d, {31'b0, e});
    endtask

    task automatic wr(logic [AW-1:0] a, logic [1:0] v);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // Single change on port p, with txn_busy held for d cycles after the write.
    task automatic change(int p, logic [1:0] v, int d);
        logic [1:0] cur;
        string req;
        cur = exp_en[p];
        req = (v == cur) ? "R6" : (((cur & ~v) != 0) ? "R5" : "R4");
        txn_busy[p] = (d > 0);
        wr(ctl_addr(p), v);
        if (v == cur) begin
            chk_status(req, 1'b0);
            chk_port(req, p, cur);
            wait_n(d);
            txn_busy[p] = 1'b0;
            return;
        end
        if ((cur & ~v) != 0) begin
            wait_n(d);
            txn_busy[p] = 1'b0;
            wait_n(N);
        end else begin
            wait_n(N - 1);
        end
        chk_port(req, p, cur);
        chk_status("R3", 1'b1);
        wait_n(1);
        txn_busy[p] = 1'b0;
        chk_port(req, p, v);
        chk_status("R3", 1'b0);
        exp_en[p] = v;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [DW-1:0] d;
        int unsigned seed;
        for (int p = 0; p < NP; p++) exp_en[p] = 2'b00;
        wait_n(3);
        rst_n = 1'b1;

        // R1: reset state
        for (int p = 0; p < NP; p++) chk_port("R1", p, 2'b00);
        chk_status("R1", 1'b0);

        // R8: identification register
        rd(AW'(12'hFE8), d);
        chk("R8", "id", d, 32'h0000_0050);

        // R4, R6, R5 directed on port 0
        change(0, 2'b11, 0);
        change(0, 2'b11, 0);
        change(0, 2'b00, 3);

        // R5 partial clear on port 1, R2 bit meaning
        change(1, 2'b11, 0);
        change(1, 2'b10, 2);
        chk("R2", "port1 snoop pin", {31'b0, snoop_en[1]}, 32'd0);
        chk("R2", "port1 dvm pin", {31'b0, dvm_en[1]}, 32'd1);

        // R10: change on port 2 leaves others alone
        change(2, 2'b01, 0);
        chk_port("R10", 1, 2'b10);
        chk_port("R10", 0, 2'b00);

        // R9: writes outside the control registers are ignored
        wr(AW'(16'h000C), 2'b11);
        wr(AW'(16'h0FE8), 2'b11);
        wr(AW'(16'h0000), 2'b11);
        wr(AW'(16'h4004), 2'b11);
        wr(AW'(16'h6000), 2'b11);
        chk_status("R9", 1'b0);
        wait_n(N + 2);
        chk_status("R9", 1'b0);
        for (int p = 0; p < NP; p++) chk_port("R9", p, exp_en[p]);

        // R7: park two writes on port 4, last wins
        wr(ctl_addr(4), 2'b01);
        chk_status("R3", 1'b1);
        wr(ctl_addr(4), 2'b10);
        wr(ctl_addr(4), 2'b11);
        chk_port("R7", 4, 2'b01);
        chk_status("R7", 1'b1);
        wait_n(N);
        chk_port("R7", 4, 2'b01);
        chk_status("R7", 1'b1);
        wait_n(1);
        chk_port("R7", 4, 2'b11);
        chk_status("R7", 1'b0);
        exp_en[4] = 2'b11;

        // Seeded random changes scored by R4/R5/R6 timing
        seed = $urandom(32'd1234);
        for (int i = 0; i < 60; i++) begin
            int p;
            int dl;
            logic [1:0] v;
            p  = int'($urandom_range(0, NP - 1));
            v  = 2'($urandom_range(0, 3));
            dl = int'($urandom_range(0, 5));
            change(p, v, dl);
        end
        for (int p = 0; p < NP; p++) chk_port("R10", p, exp_en[p]);

        report();
    end

endmodule